// File: doc/BRIEF.md
# Audio Clock Regeneration N/CTS Calculator

This block works out the pair of integers a digital display transmitter sends so that the sink can rebuild the audio sample clock from the link clock. The integers are the numerator N and the cycle time stamp CTS. Software or a control sequencer supplies three things: a 2-bit code for the audio sample rate, the pixel clock in kHz and the 2-bit colour-depth field. It then pulses `start`. The block picks N from a small rule table. Some entries in that table depend on the colour depth and on two particular pixel clocks.

CTS is then derived with a serial shift-add multiplier followed by a serial restoring divider. The colour-depth ratio of link clock to pixel clock is folded into the integer formula as a percentage scale. While the calculation runs, `busy` stays high. `done` rises for exactly one cycle, and it comes with `error` when the request cannot be served. N, CTS and the error flag are held steady between completions.

Top module: `acr_ncts_calc`

## Requirements
- R1: Colour-depth field 1 selects scale 100, field 2 selects scale 125 and field 3 selects scale 150. The scale multiplies CTS.
- R2: Colour-depth field 0 is refused. `done` asserts with `error`=1, and `n_out` and `cts_out` are both 0.
- R3: Rate code 0 selects 32 kHz with N=4096. The exception is colour-depth field 2 with a pixel clock of exactly 54054 or 74250 kHz, which gives N=8192.
- R4: Rate code 1 selects 44.1 kHz with N=6272, whatever the colour depth or pixel clock.
- R5: Rate code 2 selects 48 kHz with N=6144. The same exception as R3 gives N=8192.
- R6: Rate code 3 is invalid. `done` asserts with `error`=1, and N and CTS are both 0.
- R7: CTS = floor(pclk × (N/128) × scale / (fs/10)), where fs/10 is 3200, 4410 or 4800. The products are exact and only the final division truncates.
- R8: An accepted `start` raises `busy` on the next cycle. `done` then asserts for exactly one cycle per accepted start, and `busy` falls in the cycle after `done`.
- R9: A `start` pulse that arrives while `busy` is high is ignored. It produces no extra `done` and leaves the results unchanged.
- R10: `n_out`, `cts_out` and `error` change only in the cycle where `done` is high. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request pulse |
| rate_code | input | 2 | Sample rate: 0=32 kHz, 1=44.1 kHz, 2=48 kHz, 3=invalid |
| depth_mode | input | 2 | Colour-depth field: 0=invalid, 1=8-bit, 2=10-bit, 3=12-bit |
| pclk_khz | input | PCLK_W | Pixel clock in kHz |
| busy | output | 1 | Calculation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last request was refused |
| n_out | output | N_W | Selected N |
| cts_out | output | CTS_W | Computed CTS |

## Verification
The bench sweeps every rate code against every colour-depth field over a set of pixel clocks. That set includes the two exception clocks, a neighbour one kHz below one of them, and the largest clock the input width allows. A table that applied the 8192 exception at 44.1 kHz, or at the wrong depth, would report the wrong N at exactly those points. A divider that truncated too early or lost its top bit would give a wrong CTS at the largest clock. The invalid rate code and depth field 0 must both give a one-cycle `done` with zeroed outputs; a design that only flagged the error, or left stale values, fails there. A `start` pulse injected mid-calculation and input changes after completion expose a block that restarts while busy or lets its outputs follow the inputs.

// File: rtl/acr_calc_pkg.sv
package acr_calc_pkg;

   typedef enum logic [1:0] {
      FS_32K  = 2'd0,
      FS_44K1 = 2'd1,
      FS_48K  = 2'd2,
      FS_NONE = 2'd3
   } fs_code_e;

   localparam int unsigned NDIV_W   = 7;    // N/128 fits 0..64
   localparam int unsigned SCALE_W  = 8;    // percent scale up to 150
   localparam int unsigned FSD_W    = 13;   // fs/10 up to 4800
   localparam int unsigned FACT_W   = 14;   // (N/128)*scale up to 9600
   localparam int unsigned SPEC_NUM = 2;

   localparam int unsigned N_BASE_32K  = 4096;
   localparam int unsigned N_BASE_44K1 = 6272;
   localparam int unsigned N_BASE_48K  = 6144;
   localparam int unsigned N_ALT       = 8192;

   function automatic int unsigned spec_clk(int idx);
      return (idx == 0) ? 54054 : 74250;
   endfunction

   function automatic logic [SCALE_W-1:0] depth_scale(logic [1:0] d);
      case (d)
         2'd1:    return SCALE_W'(100);
         2'd2:    return SCALE_W'(125);
         2'd3:    return SCALE_W'(150);
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/acr_n_select.sv
module acr_n_select
   import acr_calc_pkg::*;
#(
   parameter int unsigned PCLK_W = 18,
   parameter int unsigned N_W    = 20
) (
   input  logic [1:0]         rate_code,
   input  logic [1:0]         depth,
   input  logic [PCLK_W-1:0]  pclk,
   output logic [N_W-1:0]     n_val,
   output logic [NDIV_W-1:0]  n_div,
   output logic [SCALE_W-1:0] scale,
   output logic [FSD_W-1:0]   fs_div,
   output logic               bad
);

   logic [SPEC_NUM-1:0] clk_hit;
   logic                alt_n;
   logic                rate_bad;
   int unsigned         n_int;

   for (genvar gi = 0; gi < SPEC_NUM; gi++) begin : g_spec
      assign clk_hit[gi] = (pclk == PCLK_W'(spec_clk(gi)));
   end

   assign alt_n = (depth == 2'd2) && (|clk_hit);
   assign scale = depth_scale(depth);

   always_comb begin
      rate_bad = 1'b0;
      fs_div   = '0;
      n_int    = 0;
      case (fs_code_e'(rate_code))
         FS_32K: begin
            n_int  = alt_n ? N_ALT : N_BASE_32K;
            fs_div = FSD_W'(3200);
         end
         FS_44K1: begin
            n_int  = N_BASE_44K1;
            fs_div = FSD_W'(4410);
         end
         FS_48K: begin
            n_int  = alt_n ? N_ALT : N_BASE_48K;
            fs_div = FSD_W'(4800);
         end
         default: rate_bad = 1'b1;
      endcase
   end

   assign bad   = rate_bad || (scale == '0);
   assign n_val = N_W'(n_int);
   assign n_div = NDIV_W'(n_int >> 7);

endmodule

// File: rtl/acr_seq_mul.sv
module acr_seq_mul #(
   parameter int unsigned A_W = 18,
   parameter int unsigned B_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [A_W-1:0]     a,
   input  logic [B_W-1:0]     b,
   output logic               fin,
   output logic [A_W+B_W-1:0] prod
);

   localparam int unsigned P_W   = A_W + B_W;
   localparam int unsigned CNT_W = (B_W > 1) ? $clog2(B_W) : 1;

   logic             run;
   logic [CNT_W-1:0] cnt;
   logic [P_W-1:0]   acc;
   logic [P_W-1:0]   mcand;
   logic [B_W-1:0]   mpl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         fin   <= 1'b0;
         cnt   <= '0;
         acc   <= '0;
         mcand <= '0;
         mpl   <= '0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            run   <= 1'b1;
            cnt   <= '0;
            acc   <= '0;
            mcand <= P_W'(a);
            mpl   <= b;
         end else if (run) begin
            if (mpl[0]) acc <= acc + mcand;
            mcand <= mcand << 1;
            mpl   <= mpl >> 1;
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(B_W - 1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign prod = acc;

   // R9: the sequencer never restarts a running multiplier
   p_mul_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !run);

   // R8: completion pulse is never doubled
   p_mul_fin_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);

endmodule

// File: rtl/acr_seq_div.sv
module acr_seq_div #(
   parameter int unsigned NUM_W = 32,
   parameter int unsigned DEN_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             fin,
   output logic [NUM_W-1:0] quo
);

   localparam int unsigned CNT_W = $clog2(NUM_W);

   logic             run;
   logic [CNT_W-1:0] cnt;
   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] den_q;
   logic [NUM_W-1:0] dvd;
   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             fits;

   always_comb begin
      trial = {rem, dvd[NUM_W-1]};
      fits  = (trial >= {1'b0, den_q});
      diff  = trial - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         fin   <= 1'b0;
         cnt   <= '0;
         rem   <= '0;
         den_q <= '0;
         dvd   <= '0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            run   <= 1'b1;
            cnt   <= '0;
            rem   <= '0;
            den_q <= den;
            dvd   <= num;
         end else if (run) begin
            rem <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            dvd <= {dvd[NUM_W-2:0], fits};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(NUM_W - 1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign quo = dvd;

   // R7: divisor handed over is never zero
   p_den_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (den != '0));

   // R7: partial remainder stays below the divisor
   p_rem_below_den_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (rem < den_q));

endmodule

// File: rtl/acr_ncts_calc.sv
module acr_ncts_calc
   import acr_calc_pkg::*;
#(
   parameter int unsigned PCLK_W = 18,
   parameter int unsigned N_W    = 20,
   parameter int unsigned CTS_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        rate_code,
   input  logic [1:0]        depth_mode,
   input  logic [PCLK_W-1:0] pclk_khz,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [N_W-1:0]    n_out,
   output logic [CTS_W-1:0]  cts_out
);

   localparam int unsigned PROD_W = PCLK_W + FACT_W;

   if (PCLK_W < 17) begin : g_bad_pclk
      $error("PCLK_W too narrow for the exception clocks");
   end
   if (N_W < 14) begin : g_bad_n
      $error("N_W too narrow for N=8192");
   end
   if (CTS_W < PCLK_W + 2 || CTS_W >= PROD_W) begin : g_bad_cts
      $error("CTS_W must hold 2.5 x pixel clock");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DIV, ST_FIN} state_e;

   state_e              state;
   logic [N_W-1:0]      n_sel;
   logic [NDIV_W-1:0]   n_div;
   logic [SCALE_W-1:0]  scale;
   logic [FSD_W-1:0]    fs_div;
   logic                bad;
   logic [FACT_W-1:0]   factor;
   logic                accept;
   logic                mul_go;
   logic                mul_fin;
   logic [PROD_W-1:0]   prod;
   logic                div_fin;
   logic [PROD_W-1:0]   quo;
   logic [N_W-1:0]      n_pend;
   logic [FSD_W-1:0]    fsd_q;

   acr_n_select #(.PCLK_W(PCLK_W), .N_W(N_W)) u_nsel (
      .rate_code (rate_code),
      .depth     (depth_mode),
      .pclk      (pclk_khz),
      .n_val     (n_sel),
      .n_div     (n_div),
      .scale     (scale),
      .fs_div    (fs_div),
      .bad       (bad)
   );

   assign factor = FACT_W'(n_div) * FACT_W'(scale);
   assign accept = start && (state == ST_IDLE);
   assign mul_go = accept && !bad;

   acr_seq_mul #(.A_W(PCLK_W), .B_W(FACT_W)) u_mul (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (mul_go),
      .a    (pclk_khz),
      .b    (factor),
      .fin  (mul_fin),
      .prod (prod)
   );

   acr_seq_div #(.NUM_W(PROD_W), .DEN_W(FSD_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (mul_fin),
      .num  (prod),
      .den  (fsd_q),
      .fin  (div_fin),
      .quo  (quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         n_pend  <= '0;
         fsd_q   <= '0;
         n_out   <= '0;
         cts_out <= '0;
         error   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (bad) begin
                     state   <= ST_FIN;
                     n_out   <= '0;
                     cts_out <= '0;
                     error   <= 1'b1;
                  end else begin
                     state  <= ST_MUL;
                     n_pend <= n_sel;
                     fsd_q  <= fs_div;
                  end
               end
            end
            ST_MUL: if (mul_fin) state <= ST_DIV;
            ST_DIV: begin
               if (div_fin) begin
                  state   <= ST_FIN;
                  n_out   <= n_pend;
                  cts_out <= quo[CTS_W-1:0];
                  error   <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done = (state == ST_FIN);
   assign busy = (state != ST_IDLE);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_no_early_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_err_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (n_out == '0 && cts_out == '0));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(n_out) && $stable(cts_out) && $stable(error)));

   p_n_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !error) |-> (n_out == N_W'(4096) || n_out == N_W'(6144) ||
                            n_out == N_W'(6272) || n_out == N_W'(8192)));

   p_cts_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      div_fin |-> ((quo >> CTS_W) == '0));

endmodule

// File: tb/acr_ncts_calc_tb.sv
module acr_ncts_calc_tb;

   localparam int PCLK_W = 18;
   localparam int N_W    = 20;
   localparam int CTS_W  = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [1:0]        rate_code = '0;
   logic [1:0]        depth_mode = '0;
   logic [PCLK_W-1:0] pclk_khz = '0;
   logic              busy, done, error;
   logic [N_W-1:0]    n_out;
   logic [CTS_W-1:0]  cts_out;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit reported = 0;

   acr_ncts_calc #(.PCLK_W(PCLK_W), .N_W(N_W), .CTS_W(CTS_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rate_code(rate_code),
      .depth_mode(depth_mode), .pclk_khz(pclk_khz), .busy(busy),
      .done(done), .error(error), .n_out(n_out), .cts_out(cts_out)
   );

   always #10 clk = ~clk;

   task automatic summary();
      if (!reported) begin
         reported = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: act=timeout exp=finish");
         summary();
      end
   end

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic model(int r, int d, int p, output longint n, output longint c,
                        output bit err);
      longint sc, fsd;
      bit     sp;
      sc  = (d == 1) ? 100 : (d == 2) ? 125 : (d == 3) ? 150 : 0;
      sp  = (d == 2) && (p == 54054 || p == 74250);
      err = (r == 3) || (d == 0);
      case (r)
         0: begin n = sp ? 8192 : 4096; fsd = 3200; end
         1: begin n = 6272; fsd = 4410; end
         default: begin n = sp ? 8192 : 6144; fsd = 4800; end
      endcase
      if (err) begin n = 0; c = 0; end
      else c = longint'(p) * (n / 128) * sc / fsd;
   endtask

   // Runs one request; if stray is set, a start with other inputs is
   // pulsed mid-calculation (R9). Returns observed values.
   task automatic run(int r, int d, int p, bit stray,
                      output longint n_a, output longint c_a, output bit e_a);
      int wait_c;
      int dones;
      @(negedge clk);
      rate_code = 2'(r); depth_mode = 2'(d); pclk_khz = PCLK_W'(p);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 busy after start", busy, 1);
      wait_c = 0;
      dones = 0;
      while (!done && wait_c < 200) begin
         if (stray && wait_c == 5) begin
            rate_code = 2'd1; depth_mode = 2'd3; pclk_khz = PCLK_W'(1000);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end else begin
            @(negedge clk);
         end
         wait_c++;
      end
      chk("R8 done seen", done, 1);
      n_a = n_out; c_a = cts_out; e_a = error;
      @(negedge clk);
      chk("R8 done one cycle", done, 0);
      chk("R8 busy low after done", busy, 0);
      if (stray) begin
         repeat (60) begin
            @(negedge clk);
            if (done) dones++;
         end
         chk("R9 no extra done", dones, 0);
      end
   endtask

   initial begin
      longint n_e, c_e, n_a, c_a;
      bit     e_e, e_a;
      int     plist [8] = '{1, 25175, 27000, 54053, 54054, 74250, 148500, 262143};

      repeat (3) @(negedge clk);
      chk("R10 reset busy", busy, 0);
      chk("R10 reset done", done, 0);
      chk("R10 reset error", error, 0);
      chk("R10 reset n", n_out, 0);
      chk("R10 reset cts", cts_out, 0);
      rst_n = 1'b1;

      // R1: scale mapping at 48 kHz, 27000 kHz
      for (int d = 1; d <= 3; d++) begin
         run(2, d, 27000, 0, n_a, c_a, e_a);
         chk("R1 scale via cts", c_a, (d == 1) ? 27000 : (d == 2) ? 33750 : 40500);
      end

      // Sweep: R2 R3 R4 R5 R6 R7
      for (int r = 0; r < 4; r++) begin
         for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 8; k++) begin
               string tn;
               model(r, d, plist[k], n_e, c_e, e_e);
               run(r, d, plist[k], 0, n_a, c_a, e_a);
               tn = (d == 0) ? "R2" : (r == 0) ? "R3" : (r == 1) ? "R4" :
                    (r == 2) ? "R5" : "R6";
               chk({tn, " n"}, n_a, n_e);
               chk({tn, " error"}, e_a, e_e);
               chk(e_e ? {tn, " cts zero"} : "R7 cts", c_a, c_e);
            end
         end
      end

      // R9: stray start while busy
      model(0, 2, 74250, n_e, c_e, e_e);
      run(0, 2, 74250, 1, n_a, c_a, e_a);
      chk("R9 n unaffected", n_out, n_e);
      chk("R9 cts unaffected", cts_out, c_e);
      chk("R9 error unaffected", error, 0);

      // R10: hold after completion while inputs change
      run(1, 3, 148500, 0, n_a, c_a, e_a);
      @(negedge clk);
      rate_code = 2'd3; depth_mode = 2'd0; pclk_khz = PCLK_W'(5);
      repeat (8) @(negedge clk);
      chk("R10 n held", n_out, 6272);
      chk("R10 cts held", cts_out, 148500 * 49 * 150 / 4410);
      chk("R10 error held", error, 0);
      chk("R10 no done", done, 0);

      // R6 after a valid result: outputs forced to zero
      run(3, 1, 27000, 0, n_a, c_a, e_a);
      chk("R6 n zero", n_a, 0);
      chk("R6 cts zero", c_a, 0);
      chk("R6 error", e_a, 1);

      summary();
   end

endmodule